// File: doc/BRIEF.md
# Track/Hold Sequencer for a Two-Wire Serial Converter

This block sits inside the slave side of a two-wire (I2C) serial converter and decides when the sampling switch of an 8-bit converter tracks, when it holds, and when each successive-approximation step is clocked. It watches falling edges of the serial clock during the address byte and counts them from the most recent START or repeated START. When the address byte is addressed to this slave, it opens the sampling switch at an edge that depends on the clock mode. It closes the switch after an acquisition window. It then issues the conversion steps.

In external clock mode the serial clock itself paces the sequence. In internal clock mode an on-chip oscillator tick paces acquisition and conversion, and the block pulls the serial clock low from the start of tracking until the conversions are finished. A STOP condition or a fresh START cancels whatever is in progress. All inputs are single-cycle strobes or levels already synchronised to `clk`. All outputs are registered, so each output changes in the clock cycle after the strobe that causes it.

Top module: `adc_th_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released, `track`, `hold`, `conv_step`, `scl_low` and `done` are all 0.
- R2: With `mode_int`=0 (external clock), `track` rises on the 7th `scl_fall` after the latest START if `addr_match` is 1 in that cycle.
- R3: In external clock mode, the 8th `scl_fall` drops `track` and raises `hold`, and `track` and `hold` are never high together.
- R4: In external clock mode, each of the next 8*NUM_CONV `scl_fall` strobes gives one `conv_step` pulse. On the last of these, `hold` falls and `done` pulses. `scl_low` stays 0 throughout.
- R5: With `mode_int`=1 (internal clock), `track` and `scl_low` rise on the 9th `scl_fall` after the latest START if `addr_match` is 1. `int_tick` strobes before that edge have no effect.
- R6: In internal clock mode, `track` falls and `hold` rises on the ACQ_TICKS-th (default 2) `int_tick` after tracking began. `scl_fall` during this window changes nothing.
- R7: In internal clock mode, each later `int_tick` gives one `conv_step` pulse, for 8*NUM_CONV steps. `scl_fall` strobes are ignored, and `scl_low` stays 1.
- R8: In internal clock mode, the first `int_tick` after the last step drops `scl_low` and `hold` and pulses `done` for exactly one cycle.
- R9: If `addr_match` is 0 at the tracking edge, no `track`, `hold`, `conv_step` or `scl_low` follows until a new START.
- R10: `start_det` restarts the edge count at zero and cancels any sequence in progress, clearing `track`, `hold` and `scl_low`.
- R11: `stop_det` cancels any sequence in progress. In the next cycle `track`, `hold`, `scl_low` and `done` are 0, and later `scl_fall` strobes produce no `conv_step`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_fall | input | 1 | One-cycle strobe per serial clock falling edge |
| start_det | input | 1 | One-cycle strobe on START or repeated START |
| stop_det | input | 1 | One-cycle strobe on STOP |
| addr_match | input | 1 | Address byte is addressed to this slave |
| mode_int | input | 1 | 1 = internal clock mode, 0 = external clock mode |
| int_tick | input | 1 | One-cycle strobe per internal oscillator cycle |
| track | output | 1 | Sampling switch tracks the input |
| hold | output | 1 | Sampling switch holds the sample |
| conv_step | output | 1 | One-cycle strobe per conversion step |
| scl_low | output | 1 | Drive the serial clock low (clock stretch) |
| done | output | 1 | One-cycle strobe when the sequence completes |

## Verification
The bench builds the block with NUM_CONV=2, so every sequence runs 16 steps. This makes the step counter cross a conversion boundary, and it keeps the clock stretch held across two back-to-back conversions. ACQ_TICKS and the three trigger edges keep their defaults of 2, 7, 8 and 9. With those values the bench can reach an abort at any step of either conversion, a START that arrives partway through an address byte, and stray serial clock edges or oscillator ticks in every phase where they must be ignored.

// File: rtl/th_seq_pkg.sv
package th_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_EXT_TRK = 3'd1,
    ST_INT_ACQ = 3'd2,
    ST_CONV    = 3'd3,
    ST_RELEASE = 3'd4
  } th_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned cnt_width(input int unsigned limit);
    return (limit > 1) ? $clog2(limit) : 1;
  endfunction

endpackage

// File: rtl/th_fall_counter.sv
module th_fall_counter
  import th_seq_pkg::*;
#(
  parameter int unsigned EXT_TRACK_EDGE = 7,
  parameter int unsigned EXT_HOLD_EDGE  = 8,
  parameter int unsigned INT_TRACK_EDGE = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       scl_fall,
  output logic [2:0] hit
);
  localparam int unsigned MAX_EDGE = max3(EXT_TRACK_EDGE, EXT_HOLD_EDGE, INT_TRACK_EDGE);
  localparam int unsigned EW       = cnt_width(MAX_EDGE + 1);
  localparam int unsigned EDGES [3] = '{EXT_TRACK_EDGE, EXT_HOLD_EDGE, INT_TRACK_EDGE};

  logic [EW-1:0] edge_cnt;
  logic          at_max;

  assign at_max = (edge_cnt == EW'(MAX_EDGE));

  // Counts edges since the latest START; saturates so triggers fire once.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      edge_cnt <= '0;
    end else if (clr) begin
      edge_cnt <= '0;
    end else if (scl_fall && !at_max) begin
      edge_cnt <= edge_cnt + 1'b1;
    end
  end

  // hit[g] marks the cycle in which edge number EDGES[g] arrives.
  for (genvar g = 0; g < 3; g++) begin : g_hit
    assign hit[g] = scl_fall && !clr && (edge_cnt == EW'(EDGES[g] - 1));
  end

endmodule

// File: rtl/th_event_counter.sv
module th_event_counter
  import th_seq_pkg::*;
#(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last
);
  localparam int unsigned W = cnt_width(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  assign last = (cnt == W'(LIMIT - 1));

endmodule

// File: rtl/th_ctrl.sv
module th_ctrl
  import th_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic abort,
  input  logic mode_int,
  input  logic addr_match,
  input  logic hit_ext_trk,
  input  logic hit_ext_hold,
  input  logic hit_int_trk,
  input  logic scl_fall,
  input  logic int_tick,
  input  logic acq_last,
  input  logic step_last,
  output logic acq_clr,
  output logic acq_inc,
  output logic step_clr,
  output logic step_inc,
  output logic track,
  output logic hold,
  output logic conv_step,
  output logic scl_low,
  output logic done
);
  th_state_e state;
  logic      mode_q;
  logic      conv_ev;

  // Step clock source follows the mode captured when tracking began.
  assign conv_ev  = mode_q ? int_tick : scl_fall;
  assign acq_inc  = (state == ST_INT_ACQ) && int_tick;
  assign acq_clr  = abort || (state != ST_INT_ACQ);
  assign step_inc = (state == ST_CONV) && conv_ev;
  assign step_clr = abort || (state != ST_CONV);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      mode_q    <= 1'b0;
      track     <= 1'b0;
      hold      <= 1'b0;
      conv_step <= 1'b0;
      scl_low   <= 1'b0;
      done      <= 1'b0;
    end else begin
      conv_step <= 1'b0;
      done      <= 1'b0;
      if (abort) begin
        state   <= ST_IDLE;
        track   <= 1'b0;
        hold    <= 1'b0;
        scl_low <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if (!mode_int && hit_ext_trk && addr_match) begin
              mode_q <= 1'b0;
              track  <= 1'b1;
              state  <= ST_EXT_TRK;
            end else if (mode_int && hit_int_trk && addr_match) begin
              mode_q  <= 1'b1;
              track   <= 1'b1;
              scl_low <= 1'b1;
              state   <= ST_INT_ACQ;
            end
          end
          ST_EXT_TRK: begin
            if (hit_ext_hold) begin
              track <= 1'b0;
              hold  <= 1'b1;
              state <= ST_CONV;
            end
          end
          ST_INT_ACQ: begin
            if (int_tick && acq_last) begin
              track <= 1'b0;
              hold  <= 1'b1;
              state <= ST_CONV;
            end
          end
          ST_CONV: begin
            if (conv_ev) begin
              conv_step <= 1'b1;
              if (step_last) begin
                if (mode_q) begin
                  state <= ST_RELEASE;
                end else begin
                  hold  <= 1'b0;
                  done  <= 1'b1;
                  state <= ST_IDLE;
                end
              end
            end
          end
          ST_RELEASE: begin
            if (int_tick) begin
              hold    <= 1'b0;
              scl_low <= 1'b0;
              done    <= 1'b1;
              state   <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/adc_th_seq.sv
module adc_th_seq
  import th_seq_pkg::*;
#(
  parameter int unsigned EXT_TRACK_EDGE = 7,
  parameter int unsigned EXT_HOLD_EDGE  = 8,
  parameter int unsigned INT_TRACK_EDGE = 9,
  parameter int unsigned ACQ_TICKS      = 2,
  parameter int unsigned STEPS_PER_CONV = 8,
  parameter int unsigned NUM_CONV       = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_fall,
  input  logic start_det,
  input  logic stop_det,
  input  logic addr_match,
  input  logic mode_int,
  input  logic int_tick,
  output logic track,
  output logic hold,
  output logic conv_step,
  output logic scl_low,
  output logic done
);
  localparam int unsigned TOTAL_STEPS = STEPS_PER_CONV * NUM_CONV;

  logic       abort;
  logic [2:0] hit;
  logic       acq_clr, acq_inc, acq_last;
  logic       step_clr, step_inc, step_last;

  assign abort = start_det || stop_det;

  th_fall_counter #(
    .EXT_TRACK_EDGE (EXT_TRACK_EDGE),
    .EXT_HOLD_EDGE  (EXT_HOLD_EDGE),
    .INT_TRACK_EDGE (INT_TRACK_EDGE)
  ) u_edges (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (abort),
    .scl_fall (scl_fall),
    .hit      (hit)
  );

  th_event_counter #(.LIMIT(ACQ_TICKS)) u_acq (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (acq_clr),
    .inc   (acq_inc),
    .last  (acq_last)
  );

  th_event_counter #(.LIMIT(TOTAL_STEPS)) u_steps (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (step_clr),
    .inc   (step_inc),
    .last  (step_last)
  );

  th_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .abort        (abort),
    .mode_int     (mode_int),
    .addr_match   (addr_match),
    .hit_ext_trk  (hit[0]),
    .hit_ext_hold (hit[1]),
    .hit_int_trk  (hit[2]),
    .scl_fall     (scl_fall),
    .int_tick     (int_tick),
    .acq_last     (acq_last),
    .step_last    (step_last),
    .acq_clr      (acq_clr),
    .acq_inc      (acq_inc),
    .step_clr     (step_clr),
    .step_inc     (step_inc),
    .track        (track),
    .hold         (hold),
    .conv_step    (conv_step),
    .scl_low      (scl_low),
    .done         (done)
  );

endmodule

// File: rtl/adc_th_seq_checker.sv
module adc_th_seq_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_fall,
  input logic start_det,
  input logic stop_det,
  input logic addr_match,
  input logic mode_int,
  input logic int_tick,
  input logic track,
  input logic hold,
  input logic conv_step,
  input logic scl_low,
  input logic done
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!track && !hold && !scl_low && !done)); // R1

  AST_TRACK_HOLD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(track && hold)); // R3

  AST_STEP_UNDER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    conv_step |-> $past(hold)); // R4

  AST_STRETCH_INT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_low) |-> $past(mode_int && scl_fall)); // R5

  AST_STEP_HAS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    conv_step |-> $past(scl_fall || int_tick)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_TRACK_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(track) |-> $past(addr_match && scl_fall)); // R9

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (!track && !hold && !scl_low)); // R10

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!track && !hold && !scl_low && !done)); // R11

endmodule

bind adc_th_seq adc_th_seq_checker u_chk (.*);

// File: tb/adc_th_seq_bench.sv
module adc_th_seq_bench;
  localparam int unsigned NCONV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_fall = 1'b0, start_det = 1'b0, stop_det = 1'b0;
  logic addr_match = 1'b0, mode_int = 1'b0, int_tick = 1'b0;
  logic track, hold, conv_step, scl_low, done;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  adc_th_seq #(.NUM_CONV(NCONV)) u_adc_th_seq (
    .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_match(addr_match), .mode_int(mode_int),
    .int_tick(int_tick), .track(track), .hold(hold), .conv_step(conv_step),
    .scl_low(scl_low), .done(done)
  );

  function automatic int exp_total();
    return 8 * NCONV;
  endfunction

  function automatic logic exp_track_ext(input int e, input logic m);
    return m && (e == 7);
  endfunction

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // 0 scl_fall, 1 int_tick, 2 start, 3 stop; outputs settle by the next negedge
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: scl_fall = 1'b1;
      1: int_tick = 1'b1;
      2: start_det = 1'b1;
      default: stop_det = 1'b1;
    endcase
    @(negedge clk);
    scl_fall = 1'b0; int_tick = 1'b0; start_det = 1'b0; stop_det = 1'b0;
  endtask

  task automatic idle_clear(input string req);
    chk(req, track, 1'b0);
    chk(req, hold, 1'b0);
    chk(req, scl_low, 1'b0);
    chk(req, done, 1'b0);
  endtask

  task automatic do_abort(input bit by_stop);
    strobe(by_stop ? 3 : 2);
    idle_clear(by_stop ? "R11 stop abort" : "R10 start abort");
    strobe(0);
    chk(by_stop ? "R11 no step after abort" : "R10 no step after abort", conv_step, 1'b0);
  endtask

  task automatic run_ext(input logic m, input int abort_at, input bit by_stop);
    mode_int = 1'b0;
    strobe(2);
    for (int e = 1; e <= 8; e++) begin
      addr_match = (e >= 7) ? m : logic'($urandom_range(0, 1));
      strobe(0);
      chk(m ? "R2 ext track" : "R9 no track", track, exp_track_ext(e, m));
      chk(m ? "R3 ext hold" : "R9 no hold", hold, m && (e == 8));
      chk("R4 no stretch ext", scl_low, 1'b0);
    end
    if (!m) begin
      strobe(0);
      chk("R9 no step", conv_step, 1'b0);
      return;
    end
    for (int s = 0; s < exp_total(); s++) begin
      if (s == abort_at) begin
        do_abort(by_stop);
        return;
      end
      if ($urandom_range(0, 3) == 0) strobe(1);
      strobe(0);
      chk("R4 ext step", conv_step, 1'b1);
      chk("R4 ext done", done, s == exp_total() - 1);
      chk("R4 ext hold", hold, s != exp_total() - 1);
      chk("R4 no stretch ext", scl_low, 1'b0);
    end
    strobe(0);
    chk("R4 no extra step", conv_step, 1'b0);
  endtask

  task automatic run_int(input logic m, input int abort_at, input bit by_stop);
    mode_int = 1'b1;
    strobe(2);
    for (int e = 1; e <= 9; e++) begin
      addr_match = (e >= 9) ? m : logic'($urandom_range(0, 1));
      strobe(0);
      chk(m ? "R5 int track" : "R9 no track", track, m && (e == 9));
      chk(m ? "R5 int stretch" : "R9 no stretch", scl_low, m && (e == 9));
      if (e < 9 && $urandom_range(0, 1) == 1) begin
        strobe(1);
        chk("R5 early tick ignored", track, 1'b0);
      end
    end
    if (!m) begin
      strobe(1);
      chk("R9 no hold", hold, 1'b0);
      chk("R9 no step", conv_step, 1'b0);
      return;
    end
    strobe(1);
    chk("R6 still tracking", track, 1'b1);
    chk("R6 not yet hold", hold, 1'b0);
    strobe(0);
    chk("R6 fall ignored", track, 1'b1);
    strobe(1);
    chk("R6 track off", track, 1'b0);
    chk("R6 hold on", hold, 1'b1);
    for (int s = 0; s < exp_total(); s++) begin
      if (s == abort_at) begin
        do_abort(by_stop);
        return;
      end
      if ($urandom_range(0, 2) == 0) begin
        strobe(0);
        chk("R7 fall ignored", conv_step, 1'b0);
      end
      strobe(1);
      chk("R7 int step", conv_step, 1'b1);
      chk("R7 stretch held", scl_low, 1'b1);
      chk("R7 no early done", done, 1'b0);
    end
    strobe(1);
    chk("R8 release", scl_low, 1'b0);
    chk("R8 hold off", hold, 1'b0);
    chk("R8 done", done, 1'b1);
    chk("R8 no step", conv_step, 1'b0);
    @(negedge clk);
    chk("R8 done one cycle", done, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(negedge clk);
    idle_clear("R1 in reset");
    chk("R1 in reset", conv_step, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    idle_clear("R1 after reset");

    run_ext(1'b1, -1, 1'b0);
    run_int(1'b1, -1, 1'b0);
    run_ext(1'b0, -1, 1'b0);
    run_int(1'b0, -1, 1'b0);
    run_int(1'b1, 9, 1'b1);
    run_ext(1'b1, 3, 1'b0);
    run_int(1'b1, 0, 1'b0);

    // R10 directed: a repeated START partway through the address byte
    mode_int = 1'b0; addr_match = 1'b1;
    strobe(2);
    for (int e = 0; e < 5; e++) strobe(0);
    strobe(2);
    for (int e = 1; e <= 7; e++) begin
      strobe(0);
      chk("R10 count restarts", track, e == 7);
    end

    for (int i = 0; i < 40; i++) begin
      logic m;
      int ab;
      m  = ($urandom_range(0, 3) != 0);
      ab = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, exp_total() - 1)) : -1;
      if ($urandom_range(0, 1) == 1) run_int(m, ab, $urandom_range(0, 1) == 1);
      else run_ext(m, ab, $urandom_range(0, 1) == 1);
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule